// File: doc/BRIEF.md
# Hidden Store/Recall Command Detector

This block sits beside a byte-wide static RAM port and watches the accesses to it: the address, the active-low chip enable and the active-low write enable. A host can send one of two commands without any extra pins. It does this by making six reads in a row to a fixed list of addresses. The first five addresses form a shared prefix. The sixth address picks the command: either "store" (copy the array to backup) or "recall" (copy the backup into the array). When the pattern completes, the block raises a one-cycle pulse on the matching output. A separate transfer engine acts on that pulse and reports busy while it works. The block does not carry out the transfer.

The detector is a six-state machine: `ST_IDLE` (nothing matched), then `ST_K1` to `ST_K5` (one to five prefix reads matched). It uses these transitions:
- **advance**: a read at the address expected next moves the machine one state forward.
- **restart**: a read at the wrong address goes to `ST_K1` if that address is the first prefix address, and to `ST_IDLE` otherwise.
- **fire-store** and **fire-recall**: from `ST_K5`, a read at a command address goes to `ST_IDLE` and raises the matching pulse.
- **flush**: a write, or busy being high, goes to `ST_IDLE` from any state.

Inputs are sampled on the rising clock edge. A pulse appears on the output register during the clock cycle that follows the edge at which the sixth read was sampled.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: While `rst_n` is low at a rising edge, both pulse outputs are low after that edge and the sequence returns to idle. A sequence that was partly entered before reset does not complete after it.
- R2: A read access starts in one of two ways: `ce_n` is low with `we_n` high after `ce_n` was high at the previous edge, or the address differs from the previous edge while `ce_n` is low and `we_n` is high. Each access counts once, so an address held for several cycles advances the sequence only once. There is no output-enable input: a read counts whatever the output drivers are doing.
- R3: The prefix is five reads, in this order: 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0.
- R4: A sixth read at 0x0F0F, right after the prefix, makes `store_pulse` high for exactly one cycle: the cycle after the edge that sampled that read.
- R5: A sixth read at 0x0F0E, right after the prefix, makes `recall_pulse` high for exactly one cycle, with the same timing as R4.
- R6: A read at any address other than the expected next one cancels the sequence and raises no pulse. If that read is at 0x0000, it counts as step one of a new sequence.
- R7: Any cycle with `ce_n` and `we_n` both low is a write. A write cancels the sequence, never advances it, and a pulse never follows it.
- R8: While `xfer_busy` is high, reads are not counted, the sequence returns to idle, and no pulse is raised.
- R9: After a pulse, the sequence is idle, and a new command needs all six reads again.
- R10: `store_pulse` and `recall_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (13) | Access address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| xfer_busy | input | 1 | High while a store or recall transfer is in progress |
| store_pulse | output | 1 | One-cycle store command |
| recall_pulse | output | 1 | One-cycle recall command |

## Verification
The assertions assume that the access inputs change only between clock edges, so that each level on `addr`, `ce_n` and `we_n` is sampled as a whole. They also assume that a pulse can follow only a cycle in which a read started. The stimulus drives every input on the falling edge and holds it for whole cycles. A new read starts by raising chip enable for a cycle, or by changing the address with chip enable held low. Writes always last a full cycle with both enables low, and busy is raised and dropped on whole-cycle boundaries. The bench's reference model follows the same access definition, so the holds, ce toggles, aborts and busy windows are all compared cycle by cycle.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    // Sequence progress: number of prefix reads matched so far.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5
    } seq_state_e;

    localparam int PREFIX_LEN = 5;
    localparam int KEY_W      = 16;

    localparam logic [KEY_W-1:0] STORE_KEY  = 16'h0F0F;
    localparam logic [KEY_W-1:0] RECALL_KEY = 16'h0F0E;

    // Prefix address expected at a given step (0 = first read).
    function automatic logic [KEY_W-1:0] prefix_key(input int step);
        logic [KEY_W-1:0] k;
        case (step)
            0:       k = 16'h0000;
            1:       k = 16'h1555;
            2:       k = 16'h0AAA;
            3:       k = 16'h1FFF;
            4:       k = 16'h10F0;
            default: k = 16'h0000;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nvcmd_access_det.sv
// Turns raw enable/address levels into per-access events.
module nvcmd_access_det #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    output logic              rd_start,
    output logic              wr_active
);

    logic              prev_ce_n;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ce_n <= 1'b1;
            prev_addr <= '0;
        end else begin
            prev_ce_n <= ce_n;
            prev_addr <= addr;
        end
    end

    logic rd_level;
    logic new_access;

    always_comb begin
        rd_level   = !ce_n && we_n;
        new_access = prev_ce_n || (addr != prev_addr);
        rd_start   = rd_level && new_access;
        wr_active  = !ce_n && !we_n;
    end

endmodule

// File: rtl/nvcmd_key_match.sv
// Compares the current address against every key address in parallel.
module nvcmd_key_match
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] pre_hit,
    output logic                  store_hit,
    output logic                  recall_hit
);

    localparam logic [ADDR_W-1:0] STORE_A  = ADDR_W'(STORE_KEY);
    localparam logic [ADDR_W-1:0] RECALL_A = ADDR_W'(RECALL_KEY);

    for (genvar k = 0; k < PREFIX_LEN; k++) begin : g_pre
        localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(prefix_key(k));
        assign pre_hit[k] = (addr == KEY_A);
    end

    assign store_hit  = (addr == STORE_A);
    assign recall_hit = (addr == RECALL_A);

endmodule

// File: rtl/nvcmd_seq_fsm.sv
// Six-state sequence tracker with registered command pulses.
module nvcmd_seq_fsm
    import nvcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xfer_busy,
    input  logic                  rd_start,
    input  logic                  wr_active,
    input  logic [PREFIX_LEN-1:0] pre_hit,
    input  logic                  store_hit,
    input  logic                  recall_hit,
    output logic                  store_pulse,
    output logic                  recall_pulse
);

    seq_state_e state, state_nxt;
    seq_state_e restart_st;
    logic       fire_store, fire_recall;

    always_comb begin
        restart_st  = pre_hit[0] ? ST_K1 : ST_IDLE;
        state_nxt   = state;
        fire_store  = 1'b0;
        fire_recall = 1'b0;
        if (xfer_busy || wr_active) begin
            state_nxt = ST_IDLE;
        end else if (rd_start) begin
            unique case (state)
                ST_IDLE: state_nxt = restart_st;
                ST_K1:   state_nxt = pre_hit[1] ? ST_K2 : restart_st;
                ST_K2:   state_nxt = pre_hit[2] ? ST_K3 : restart_st;
                ST_K3:   state_nxt = pre_hit[3] ? ST_K4 : restart_st;
                ST_K4:   state_nxt = pre_hit[4] ? ST_K5 : restart_st;
                ST_K5: begin
                    if (store_hit) begin
                        fire_store = 1'b1;
                        state_nxt  = ST_IDLE;
                    end else if (recall_hit) begin
                        fire_recall = 1'b1;
                        state_nxt   = ST_IDLE;
                    end else begin
                        state_nxt = restart_st;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_pulse  <= 1'b0;
            recall_pulse <= 1'b0;
        end else begin
            store_pulse  <= fire_store;
            recall_pulse <= fire_recall;
        end
    end

endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              xfer_busy,
    output logic              store_pulse,
    output logic              recall_pulse
);

    logic                  rd_start;
    logic                  wr_active;
    logic [PREFIX_LEN-1:0] pre_hit;
    logic                  store_hit;
    logic                  recall_hit;

    nvcmd_access_det #(.ADDR_W(ADDR_W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .rd_start  (rd_start),
        .wr_active (wr_active)
    );

    nvcmd_key_match #(.ADDR_W(ADDR_W)) u_match (
        .addr       (addr),
        .pre_hit    (pre_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    nvcmd_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_busy    (xfer_busy),
        .rd_start     (rd_start),
        .wr_active    (wr_active),
        .pre_hit      (pre_hit),
        .store_hit    (store_hit),
        .recall_hit   (recall_hit),
        .store_pulse  (store_pulse),
        .recall_pulse (recall_pulse)
    );

endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
module nvcmd_seq_detect_chk
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              we_n,
    input logic              xfer_busy,
    input logic              store_pulse,
    input logic              recall_pulse
);

    localparam logic [ADDR_W-1:0] STORE_A  = ADDR_W'(STORE_KEY);
    localparam logic [ADDR_W-1:0] RECALL_A = ADDR_W'(RECALL_KEY);

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_pulse && recall_pulse));

    // R4
    store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> ($past(addr) == STORE_A) && !$past(ce_n) && $past(we_n) && !$past(xfer_busy));

    // R5
    recall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_pulse |-> ($past(addr) == RECALL_A) && !$past(ce_n) && $past(we_n) && !$past(xfer_busy));

    // R4
    store_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> !store_pulse);

    // R5
    recall_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_pulse |=> !recall_pulse);

    // R7
    write_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> !(store_pulse || recall_pulse));

    // R8
    busy_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> !(store_pulse || recall_pulse));

    // R2
    new_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_pulse || recall_pulse) |-> ($past(ce_n, 2) || ($past(addr, 2) != $past(addr))));

endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .ce_n         (ce_n),
    .we_n         (we_n),
    .xfer_busy    (xfer_busy),
    .store_pulse  (store_pulse),
    .recall_pulse (recall_pulse)
);

// File: tb/nvcmd_seq_detect_test.sv
module nvcmd_seq_detect_test;

    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          xfer_busy = 1'b0;
    logic          store_pulse, recall_pulse;

    always #5 clk = ~clk;

    nvcmd_seq_detect #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .xfer_busy(xfer_busy), .store_pulse(store_pulse), .recall_pulse(recall_pulse)
    );

    int    vectors = 0;
    int    fails   = 0;
    string tag     = "R1";
    int    st_cnt  = 0;
    int    rc_cnt  = 0;
    int    cycles  = 0;
    bit    done    = 1'b0;

    // Reference model: behavioural, from the requirements.
    int key_q[$] = '{'h0000, 'h1555, 'h0AAA, 'h1FFF, 'h10F0};
    int matched  = 0;
    bit m_prev_ce = 1'b1;
    int m_prev_addr = 0;
    bit exp_st = 1'b0, exp_rc = 1'b0;
    bit seen_edge = 1'b0;

    always @(posedge clk) begin
        bit is_rd;
        seen_edge = 1'b1;
        cycles++;
        if (!rst_n) begin
            matched = 0; m_prev_ce = 1'b1; m_prev_addr = 0; exp_st = 0; exp_rc = 0;
        end else begin
            is_rd = !ce_n && we_n && (m_prev_ce || int'(addr) != m_prev_addr);
            exp_st = 0; exp_rc = 0;
            if (xfer_busy || (!ce_n && !we_n)) matched = 0;
            else if (is_rd) begin
                if (matched == 5 && int'(addr) == 'h0F0F) begin exp_st = 1; matched = 0; end
                else if (matched == 5 && int'(addr) == 'h0F0E) begin exp_rc = 1; matched = 0; end
                else if (matched < 5 && int'(addr) == key_q[matched]) matched++;
                else matched = (int'(addr) == key_q[0]) ? 1 : 0;
            end
            m_prev_ce = ce_n;
            m_prev_addr = int'(addr);
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            vectors++;
            if (store_pulse !== exp_st) begin
                fails++;
                $display("FAIL %s store_pulse actual=%b expected=%b t=%0t", tag, store_pulse, exp_st, $time);
            end
            if (recall_pulse !== exp_rc) begin
                fails++;
                $display("FAIL %s recall_pulse actual=%b expected=%b t=%0t", tag, recall_pulse, exp_rc, $time);
            end
            // R10: never both
            if (store_pulse && recall_pulse) begin
                fails++;
                $display("FAIL R10 both pulses actual=11 expected=not both t=%0t", $time);
            end
            if (store_pulse) st_cnt++;
            if (recall_pulse) rc_cnt++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_ce(int a);
        ce_n = 1'b1; we_n = 1'b1; step(1);
        ce_n = 1'b0; addr = AW'(a); step(1);
    endtask

    task automatic rd_addr(int a, int hold);
        ce_n = 1'b0; we_n = 1'b1; addr = AW'(a); step(hold);
    endtask

    task automatic wr(int a);
        ce_n = 1'b0; we_n = 1'b0; addr = AW'(a); step(1);
        we_n = 1'b1; ce_n = 1'b1; step(1);
    endtask

    task automatic prefix_ce();
        foreach (key_q[i]) rd_ce(key_q[i]);
    endtask

    task automatic settle();
        ce_n = 1'b1; we_n = 1'b1; step(3);
    endtask

    task automatic count_chk(string t, int st0, int rc0, int est, int erc);
        vectors++;
        if ((st_cnt - st0) != est || (rc_cnt - rc0) != erc) begin
            fails++;
            $display("FAIL %s pulse counts actual=%0d/%0d expected=%0d/%0d", t,
                     st_cnt - st0, rc_cnt - rc0, est, erc);
        end
    endtask

    initial begin
        int s0, r0;
        tag = "R1";
        step(3);
        vectors++;
        if (store_pulse !== 1'b0 || recall_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%b%b expected=00", store_pulse, recall_pulse);
        end
        rst_n = 1'b1; step(2);

        // R3 R4: store, each read opened by a chip-enable fall
        tag = "R4"; s0 = st_cnt; r0 = rc_cnt;
        prefix_ce(); rd_ce('h0F0F); settle();
        count_chk("R4", s0, r0, 1, 0);

        // R5: recall with chip enable held low
        tag = "R5"; s0 = st_cnt; r0 = rc_cnt;
        foreach (key_q[i]) rd_addr(key_q[i], 1);
        rd_addr('h0F0E, 1); settle();
        count_chk("R5", s0, r0, 0, 1);

        // R2: held addresses count once
        tag = "R2"; s0 = st_cnt; r0 = rc_cnt;
        rd_addr('h0000, 3); rd_addr('h1555, 4); rd_addr('h0AAA, 2);
        rd_addr('h1FFF, 1); rd_addr('h10F0, 5); rd_addr('h0F0F, 3); settle();
        count_chk("R2", s0, r0, 1, 0);

        // R2: same address reopened by chip enable is a second access
        s0 = st_cnt; r0 = rc_cnt;
        rd_ce('h0000); rd_ce('h1555); rd_ce('h1555);
        rd_ce('h0AAA); rd_ce('h1FFF); rd_ce('h10F0); rd_ce('h0F0F); settle();
        count_chk("R2", s0, r0, 0, 0);

        // R3 R6: wrong prefix address aborts
        tag = "R6"; s0 = st_cnt; r0 = rc_cnt;
        rd_ce('h0000); rd_ce('h1555); rd_ce('h0AAA); rd_ce('h1234);
        rd_ce('h1FFF); rd_ce('h10F0); rd_ce('h0F0F); settle();
        count_chk("R6", s0, r0, 0, 0);

        // R6: aborting read at 0x0000 starts a fresh sequence
        s0 = st_cnt; r0 = rc_cnt;
        rd_ce('h0000); rd_ce('h1555); rd_ce('h0000); rd_ce('h1555);
        rd_ce('h0AAA); rd_ce('h1FFF); rd_ce('h10F0); rd_ce('h0F0F); settle();
        count_chk("R6", s0, r0, 1, 0);

        // R6: wrong sixth address
        s0 = st_cnt; r0 = rc_cnt;
        prefix_ce(); rd_ce('h0F0D); rd_ce('h0F0E); settle();
        count_chk("R6", s0, r0, 0, 0);

        // R7: write in the middle, and write in place of the sixth read
        tag = "R7"; s0 = st_cnt; r0 = rc_cnt;
        rd_ce('h0000); rd_ce('h1555); wr('h0AAA);
        rd_ce('h0AAA); rd_ce('h1FFF); rd_ce('h10F0); rd_ce('h0F0F); settle();
        prefix_ce(); wr('h0F0F); settle();
        prefix_ce(); wr('h0F0E); rd_ce('h0F0E); settle();
        count_chk("R7", s0, r0, 0, 0);

        // R8: busy during whole sequence, and busy for one cycle mid-way
        tag = "R8"; s0 = st_cnt; r0 = rc_cnt;
        xfer_busy = 1'b1; prefix_ce(); rd_ce('h0F0F); settle(); xfer_busy = 1'b0;
        rd_ce('h0000); rd_ce('h1555); rd_ce('h0AAA);
        ce_n = 1'b1; xfer_busy = 1'b1; step(1); xfer_busy = 1'b0;
        rd_ce('h1FFF); rd_ce('h10F0); rd_ce('h0F0E); settle();
        prefix_ce(); xfer_busy = 1'b1; rd_ce('h0F0E); xfer_busy = 1'b0; settle();
        count_chk("R8", s0, r0, 0, 0);

        // R9: after a command, repeating the last read does nothing
        tag = "R9"; s0 = st_cnt; r0 = rc_cnt;
        prefix_ce(); rd_ce('h0F0E); rd_ce('h0F0E); rd_ce('h0F0F); settle();
        count_chk("R9", s0, r0, 0, 1);

        // R1: reset mid-sequence
        tag = "R1"; s0 = st_cnt; r0 = rc_cnt;
        prefix_ce(); ce_n = 1'b1; rst_n = 1'b0; step(1); rst_n = 1'b1;
        rd_ce('h0F0F); settle();
        count_chk("R1", s0, r0, 0, 0);

        // R10: back-to-back store then recall
        tag = "R10"; s0 = st_cnt; r0 = rc_cnt;
        prefix_ce(); rd_ce('h0F0F); prefix_ce(); rd_ce('h0F0E); settle();
        count_chk("R10", s0, r0, 1, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule